// File: doc/BRIEF.md
# Prioritized Two-Counter Update Arbiter

This block keeps two unsigned counters, a source count and a sink count, that three competing update processes modify. The first process adds one to the source count. The second moves one unit from the source count to the sink count, so it decrements the source and increments the sink in the same cycle. The third process subtracts one from the sink count. Each process has its own request input, and each request can change from one cycle to the next.

Every cycle the block decides which processes fire. Each counter accepts at most one update per cycle, and the transfer is never split across cycles. Conflicts follow a fixed priority: the third process is highest, the transfer is next, and the increment is lowest. The increment and the sink decrement touch different counters, so they fire together when the transfer is not firing. The counters and a registered vector of grant flags, one bit per process, change on the same clock edge.

Top module: `dual_counter_arbiter`

## Requirements
- R1: After reset both counters read zero and the grant vector reads zero.
- R2: The sink-decrement grant (bit 2 of the grant vector) is set in the cycle after any cycle in which reqDrain is high, whatever the other requests are.
- R3: The transfer grant (bit 1) is set exactly when reqMove was high and reqDrain was low in the previous cycle.
- R4: The increment grant (bit 0) is set exactly when reqFill was high and the transfer did not fire in the previous cycle.
- R5: When the transfer fires, the source count falls by one and the sink count rises by one on the same edge. Neither change ever happens without the other.
- R6: When the increment and sink-decrement both fire in one cycle, the source count rises by one and the sink count falls by one.
- R7: A counter whose every relevant request is low, or whose requests were all denied, holds its value.
- R8: Both counters are WIDTH-bit unsigned values that wrap modulo 2^WIDTH on overflow and underflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqFill | input | 1 | Request to add one to the source count |
| reqMove | input | 1 | Request to move one unit from source to sink |
| reqDrain | input | 1 | Request to subtract one from the sink count |
| srcCount | output | WIDTH | Source counter value |
| sinkCount | output | WIDTH | Sink counter value |
| fired | output | 3 | Registered grants: bit 0 fill, bit 1 move, bit 2 drain |

## Verification
The bench steps through all eight request combinations, holding each one for several cycles. These runs separate the case where the transfer is blocked by a drain from the case where the transfer itself blocks a fill, and they show fill and drain firing together. A long random phase checks the grants and both counts against a behavioural model on every clock. Draining from zero and filling long runs carry the counters across the wrap point in both directions.

// File: rtl/dca_pkg.sv
package dca_pkg;
  typedef struct packed {
    logic fill;
    logic move;
    logic drain;
  } strobe_t;
endpackage

// File: rtl/dca_control.sv
module dca_control
  import dca_pkg::*;
(
  input  logic    reqFill,
  input  logic    reqMove,
  input  logic    reqDrain,
  output strobe_t strobes
);
  always_comb begin
    strobes.drain = reqDrain;
    strobes.move  = reqMove && !reqDrain;
    strobes.fill  = reqFill && !(reqMove && !reqDrain);
  end
endmodule

// File: rtl/dca_datapath.sv
module dca_datapath
  import dca_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  output logic [WIDTH-1:0] srcCount,
  output logic [WIDTH-1:0] sinkCount,
  output logic [2:0]       fired
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] srcNext, sinkNext;

  always_comb begin
    srcNext  = srcCount;
    sinkNext = sinkCount;
    if (strobes.move)      srcNext = srcCount - ONE;
    else if (strobes.fill) srcNext = srcCount + ONE;
    if (strobes.drain)     sinkNext = sinkCount - ONE;
    else if (strobes.move) sinkNext = sinkCount + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcCount  <= '0;
      sinkCount <= '0;
      fired     <= '0;
    end else begin
      srcCount  <= srcNext;
      sinkCount <= sinkNext;
      fired     <= {strobes.drain, strobes.move, strobes.fill};
    end
  end
endmodule

// File: rtl/dual_counter_arbiter.sv
module dual_counter_arbiter
  import dca_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqFill,
  input  logic             reqMove,
  input  logic             reqDrain,
  output logic [WIDTH-1:0] srcCount,
  output logic [WIDTH-1:0] sinkCount,
  output logic [2:0]       fired
);
  strobe_t strobes;

  dca_control u_control (
    .reqFill (reqFill),
    .reqMove (reqMove),
    .reqDrain(reqDrain),
    .strobes (strobes)
  );

  dca_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .srcCount (srcCount),
    .sinkCount(sinkCount),
    .fired    (fired)
  );
endmodule

// File: rtl/dca_checker.sv
module dca_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqFill,
  input logic             reqMove,
  input logic             reqDrain,
  input logic [WIDTH-1:0] srcCount,
  input logic [WIDTH-1:0] sinkCount,
  input logic [2:0]       fired
);
  logic primed;
  always_ff @(posedge clk) primed <= rstN;

  assert_drain_grant_R2: assert property (@(posedge clk) disable iff (!rstN)
    primed |-> (fired[2] == $past(reqDrain)));

  assert_move_grant_R3: assert property (@(posedge clk) disable iff (!rstN)
    primed |-> (fired[1] == ($past(reqMove) && !$past(reqDrain))));

  assert_fill_grant_R4: assert property (@(posedge clk) disable iff (!rstN)
    primed |-> (fired[0] == ($past(reqFill) && !fired[1])));

  assert_atomic_move_R5: assert property (@(posedge clk) disable iff (!rstN)
    (primed && fired[1]) |->
      (srcCount == $past(srcCount) - WIDTH'(1)) && (sinkCount == $past(sinkCount) + WIDTH'(1)));

  assert_hold_src_R7: assert property (@(posedge clk) disable iff (!rstN)
    (primed && !fired[0] && !fired[1]) |-> $stable(srcCount));

  assert_hold_sink_R7: assert property (@(posedge clk) disable iff (!rstN)
    (primed && !fired[1] && !fired[2]) |-> $stable(sinkCount));

  assert_grant_mutex_R3: assert property (@(posedge clk) disable iff (!rstN)
    primed |-> !(fired[1] && (fired[0] || fired[2])));
endmodule

bind dual_counter_arbiter dca_checker #(.WIDTH(WIDTH)) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .reqFill  (reqFill),
  .reqMove  (reqMove),
  .reqDrain (reqDrain),
  .srcCount (srcCount),
  .sinkCount(sinkCount),
  .fired    (fired)
);

// File: tb/tb_dual_counter_arbiter.sv
`timescale 1ns/1ps
module tb_dual_counter_arbiter;
  localparam int WIDTH = 8;
  localparam int MOD = 1 << WIDTH;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqFill = 1'b0, reqMove = 1'b0, reqDrain = 1'b0;
  logic [WIDTH-1:0] srcCount, sinkCount;
  logic [2:0] fired;

  int checks = 0;
  int errors = 0;
  int mSrc = 0, mSink = 0;
  logic [2:0] mFired = '0;
  bit modelOn = 1'b0;
  bit sawWrapDown = 1'b0, sawWrapUp = 1'b0, sawBoth = 1'b0;

  always #2 clk = ~clk;

  dual_counter_arbiter #(.WIDTH(WIDTH)) dut (
    .clk(clk), .rstN(rstN), .reqFill(reqFill), .reqMove(reqMove),
    .reqDrain(reqDrain), .srcCount(srcCount), .sinkCount(sinkCount), .fired(fired)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model updated at each edge from the requests in force
  always @(posedge clk) begin
    if (!rstN) begin
      mSrc <= 0; mSink <= 0; mFired <= '0;
    end else begin
      automatic bit gd = reqDrain;
      automatic bit gm = reqMove && !reqDrain;
      automatic bit gf = reqFill && !gm;
      automatic int s = mSrc, k = mSink;
      if (gm) begin s = s - 1; k = k + 1; end
      if (gf) s = s + 1;
      if (gd) k = k - 1;
      if (gm && mSrc == 0) sawWrapDown = 1'b1;
      if (gd && mSink == 0) sawWrapDown = 1'b1;
      if (gf && mSrc == MOD - 1) sawWrapUp = 1'b1;
      if (gf && gd) sawBoth = 1'b1;
      mSrc <= (s % MOD + MOD) % MOD;
      mSink <= (k % MOD + MOD) % MOD;
      mFired <= {gd, gm, gf};
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (modelOn) begin
      check("R2 drain grant", int'(fired[2]), int'(mFired[2]));
      check("R3 move grant", int'(fired[1]), int'(mFired[1]));
      check("R4 fill grant", int'(fired[0]), int'(mFired[0]));
      check(mFired[1] ? "R5 src count" : (mFired == 3'b101 ? "R6 src count" : "R7 R8 src count"),
            int'(srcCount), mSrc);
      check(mFired[1] ? "R5 sink count" : (mFired == 3'b101 ? "R6 sink count" : "R7 R8 sink count"),
            int'(sinkCount), mSink);
    end
  end

  task automatic drive(input logic [2:0] r, input int n);
    @(negedge clk);
    {reqDrain, reqMove, reqFill} = r;
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 src reset", int'(srcCount), 0);
    check("R1 sink reset", int'(sinkCount), 0);
    check("R1 fired reset", int'(fired), 0);
    rstN = 1'b1;
    modelOn = 1'b1;
    // drain from zero first: sink wraps down (R8)
    drive(3'b100, 3);
    // every combination held several cycles
    for (int c = 0; c < 8; c++) drive(c[2:0], 4);
    // long fill run wraps source up (R8)
    drive(3'b001, MOD + 5);
    // transfer-only run, then fill and drain together (R6)
    drive(3'b010, 10);
    drive(3'b101, 6);
    for (int i = 0; i < 3000; i++) drive(3'($urandom_range(0, 7)), 1);
    drive(3'b000, 3);
    check("R8 wrap down seen", int'(sawWrapDown), 1);
    check("R8 wrap up seen", int'(sawWrapUp), 1);
    check("R6 joint fire seen", int'(sawBoth), 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule